// File: doc/BRIEF.md
# Staged Clock-Synthesizer Control Registers

This block is the byte-wide register file of a clock synthesizer. It is reached over a plain parallel port with address, write data, write strobe, read strobe and read data. It holds the mode, loop, output-control and reference-divider settings, and drives them as configuration buses into the synthesizer datapath.

The PLL parameter registers (indices 0x1 to 0x3) and the delay-adjust register (index 0x5) are shadowed. A write to one of them lands only in its staged copy. The datapath keeps seeing the old working copy until software writes a recognised command pattern to the write-only command register at 0x8. Each pattern also sends a one-cycle reset pulse to its own subsystem.

Reads return the staged value of each register. Three read-only locations return a version code, a revision code and the live lock indication.

Top module: `clksyn_regbank`

## Requirements
- R1: After reset, every staged and working copy is 0x00, except index 0x7, which is 0x80 (input select = 1, divider modulus = 0). Both reset pulses are low and read data is 0x00.
- R2: A write to a direct register (indices 0x0, 0x4, 0x6, 0x7) appears on its configuration bus one cycle after the write. It also reads back. In index 0x6, bits 4:0 are output enables (1 = driven), bit 5 inverts the half-rate clock, and bits 7:6 select the divider (00/01/10/11 = /1, /2, /4, /8). In index 0x7, bits 6:0 are the divider modulus and bit 7 is the input select (0 = line sync, 1 = divided oscillator).
- R3: A write to a shadowed register (0x1, 0x2, 0x3, 0x5) changes its staged copy, which reads back. The working copy on the configuration bus is unchanged.
- R4: Writing 0x8 with low nibble 0xA copies staged 0x5 into its working copy and raises `dly_rst_pulse` for exactly one cycle.
- R5: Writing 0x8 with high nibble 0x5 copies staged 0x1 to 0x3 into their working copies and raises `pll_rst_pulse` for exactly one cycle.
- R6: The value 0x5A written to 0x8 performs both R4 and R5 in the same cycle.
- R7: A value written to 0x8 that matches neither nibble pattern changes no working copy and raises no pulse.
- R8: A read of 0x10 returns 0x17 and a read of 0x11 returns 0x01. A read of 0x12 returns `pll_lock` in bit 1, with all other bits 0.
- R9: A read of 0x8 or of any unmapped address returns 0x00. Writes to read-only or unmapped addresses have no visible effect.
- R10: A write to 0x1 whose bits 2:0 are 111 keeps the previous value of those bits. A write to 0x5 whose bits 1:0 are 10 keeps the previous value of those bits. The other bits of the byte are written normally in both cases.
- R11: `rdata` is loaded at the clock edge that samples `rd_en` high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register index |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pll_lock | input | 1 | Live lock indication |
| cfg_mode | output | 8 | Working copy of index 0x0 |
| cfg_pll | output | 24 | Working copies of 0x1 (bits 7:0), 0x2 (15:8), 0x3 (23:16) |
| cfg_loop | output | 8 | Working copy of index 0x4 |
| cfg_dly | output | 8 | Working copy of index 0x5 |
| cfg_out | output | 8 | Working copy of index 0x6 |
| cfg_ref | output | 8 | Working copy of index 0x7 |
| pll_rst_pulse | output | 1 | One-cycle PLL reset after a matching command |
| dly_rst_pulse | output | 1 | One-cycle delay-adjust reset after a matching command |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `addr` and `wdata` are stable whenever a strobe is high. The stimulus raises each strobe alone for exactly one cycle, and only changes inputs on the falling clock edge.

The sweeps write every address and read all 32 locations after each write. They try every byte value in both reserved-code fields, and every byte value as a command, with fresh staged contents before each command.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
   localparam int unsigned N_CFG     = 8;
   localparam int unsigned CMD_IDX   = 8;
   localparam int unsigned VER_IDX   = 16;
   localparam int unsigned REV_IDX   = 17;
   localparam int unsigned STS_IDX   = 18;
   localparam logic [7:0]  VER_CODE  = 8'h17;
   localparam logic [7:0]  REV_CODE  = 8'h01;
   localparam logic [3:0]  DLY_NIB   = 4'hA;
   localparam logic [3:0]  PLL_NIB   = 4'h5;

   typedef enum logic [1:0] {GRP_NONE, GRP_PLL, GRP_DLY} load_grp_e;

   function automatic load_grp_e grp_of(int unsigned idx);
      if (idx >= 1 && idx <= 3) return GRP_PLL;
      if (idx == 5)             return GRP_DLY;
      return GRP_NONE;
   endfunction

   function automatic int unsigned rst_of(int unsigned idx);
      return (idx == 7) ? 32'h80 : 32'h0;
   endfunction

   function automatic bit rsv_has(int unsigned idx);
      return (idx == 1) || (idx == 5);
   endfunction

   function automatic int unsigned rsv_width(int unsigned idx);
      return (idx == 1) ? 3 : 2;
   endfunction

   function automatic int unsigned rsv_code(int unsigned idx);
      return (idx == 1) ? 7 : 2;
   endfunction
endpackage

// File: rtl/csr_shadow_reg.sv
module csr_shadow_reg #(
   parameter int unsigned DW       = 8,
   parameter int unsigned RST_VAL  = 0,
   parameter bit          SHADOW   = 1'b0,
   parameter bit          HAS_RSV  = 1'b0,
   parameter int unsigned RSV_LSB  = 0,
   parameter int unsigned RSV_W    = 1,
   parameter int unsigned RSV_CODE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wd,
   input  logic          ld,
   output logic [DW-1:0] stg,
   output logic [DW-1:0] wrk
);
   localparam logic [DW-1:0] RV = DW'(RST_VAL);

   if (RSV_LSB + RSV_W > DW) begin : g_bad_field
      $error("reserved field exceeds register width");
   end

   logic [DW-1:0] stg_q;
   logic [DW-1:0] nxt;

   if (HAS_RSV) begin : g_rsv
      localparam logic [RSV_W-1:0] CODE = RSV_W'(RSV_CODE);
      always_comb begin
         nxt = wd;
         if (wd[RSV_LSB +: RSV_W] == CODE) nxt[RSV_LSB +: RSV_W] = stg_q[RSV_LSB +: RSV_W];
      end
      // R10
      rsv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && wd[RSV_LSB +: RSV_W] == CODE) |=>
            stg_q[RSV_LSB +: RSV_W] == $past(stg_q[RSV_LSB +: RSV_W]));
   end else begin : g_norsv
      assign nxt = wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stg_q <= RV;
      else if (wr) stg_q <= nxt;
   end
   assign stg = stg_q;

   if (SHADOW) begin : g_shadow
      logic [DW-1:0] wrk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  wrk_q <= RV;
         else if (ld) wrk_q <= stg_q;
      end
      assign wrk = wrk_q;
      // R3
      wrk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ld |=> $stable(wrk_q));
      // R4
      wrk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ld |=> wrk_q == $past(stg_q));
   end else begin : g_direct
      assign wrk = stg_q;
      // R2
      direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && !ld && !HAS_RSV) |=> wrk == $past(wd));
   end
endmodule

// File: rtl/csr_cmd_decode.sv
module csr_cmd_decode #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wd,
   output logic          ld_pll,
   output logic          ld_dly,
   output logic          pll_pulse,
   output logic          dly_pulse
);
   import clksyn_pkg::*;

   logic hit;
   assign hit    = wr && (addr == AW'(CMD_IDX));
   assign ld_dly = hit && (wd[3:0] == DLY_NIB);
   assign ld_pll = hit && (wd[7:4] == PLL_NIB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_pulse <= 1'b0;
         dly_pulse <= 1'b0;
      end else begin
         pll_pulse <= ld_pll;
         dly_pulse <= ld_dly;
      end
   end

   // R7
   no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wd[3:0] != DLY_NIB && wd[7:4] != PLL_NIB) |=> (!pll_pulse && !dly_pulse));
   // R6
   both_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wd == {PLL_NIB, DLY_NIB}) |=> (pll_pulse && dly_pulse));
   // R5
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (!pll_pulse && !dly_pulse));
endmodule

// File: rtl/csr_read_port.sv
module csr_read_port #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 8,
   parameter int unsigned NR = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [AW-1:0]    addr,
   input  logic [NR*DW-1:0] regs,
   input  logic             lock,
   output logic [DW-1:0]    rdata
);
   import clksyn_pkg::*;

   logic [DW-1:0] sel;

   always_comb begin
      sel = '0;
      if (32'(addr) < NR)               sel = regs[32'(addr)*DW +: DW];
      else if (addr == AW'(VER_IDX))    sel = DW'(VER_CODE);
      else if (addr == AW'(REV_IDX))    sel = DW'(REV_CODE);
      else if (addr == AW'(STS_IDX))    sel[1] = lock;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= sel;
   end

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));
   // R8
   sts_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == AW'(STS_IDX)) |=> rdata == DW'({$past(lock), 1'b0}));
   // R9
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && 32'(addr) >= NR && addr != AW'(VER_IDX) && addr != AW'(REV_IDX)
          && addr != AW'(STS_IDX)) |=> rdata == '0);
endmodule

// File: rtl/clksyn_regbank.sv
module clksyn_regbank #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic [DW-1:0] rdata,
   input  logic          pll_lock,
   output logic [DW-1:0] cfg_mode,
   output logic [3*DW-1:0] cfg_pll,
   output logic [DW-1:0] cfg_loop,
   output logic [DW-1:0] cfg_dly,
   output logic [DW-1:0] cfg_out,
   output logic [DW-1:0] cfg_ref,
   output logic          pll_rst_pulse,
   output logic          dly_rst_pulse
);
   import clksyn_pkg::*;

   localparam int unsigned NR = N_CFG;

   if (AW < 5) begin : g_bad_aw
      $error("address width too small for status locations");
   end
   if (DW != 8) begin : g_bad_dw
      $error("register bank is byte wide");
   end

   logic            ld_pll, ld_dly;
   logic [NR*DW-1:0] stg_bus;
   logic [NR*DW-1:0] wrk_bus;

   csr_cmd_decode #(.AW(AW), .DW(DW)) u_cmd (
      .clk(clk), .rst_n(rst_n), .wr(wr_en), .addr(addr), .wd(wdata),
      .ld_pll(ld_pll), .ld_dly(ld_dly),
      .pll_pulse(pll_rst_pulse), .dly_pulse(dly_rst_pulse)
   );

   for (genvar i = 0; i < NR; i++) begin : g_reg
      localparam load_grp_e GRP = grp_of(i);
      logic wsel, lsel;
      assign wsel = wr_en && (addr == AW'(i));
      assign lsel = (GRP == GRP_PLL) ? ld_pll : (GRP == GRP_DLY) ? ld_dly : 1'b0;
      csr_shadow_reg #(
         .DW(DW), .RST_VAL(rst_of(i)), .SHADOW(GRP != GRP_NONE),
         .HAS_RSV(rsv_has(i)), .RSV_LSB(0), .RSV_W(rsv_width(i)),
         .RSV_CODE(rsv_code(i))
      ) u_r (
         .clk(clk), .rst_n(rst_n), .wr(wsel), .wd(wdata), .ld(lsel),
         .stg(stg_bus[i*DW +: DW]), .wrk(wrk_bus[i*DW +: DW])
      );
   end

   csr_read_port #(.AW(AW), .DW(DW), .NR(NR)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(rd_en), .addr(addr),
      .regs(stg_bus), .lock(pll_lock), .rdata(rdata)
   );

   assign cfg_mode = wrk_bus[0*DW +: DW];
   assign cfg_pll  = wrk_bus[1*DW +: 3*DW];
   assign cfg_loop = wrk_bus[4*DW +: DW];
   assign cfg_dly  = wrk_bus[5*DW +: DW];
   assign cfg_out  = wrk_bus[6*DW +: DW];
   assign cfg_ref  = wrk_bus[7*DW +: DW];

   // R1
   rst_ref_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (cfg_ref == 8'h80 && cfg_pll == '0 && cfg_dly == '0));
endmodule

// File: tb/sim_clksyn_regbank.sv
module sim_clksyn_regbank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic wr_en = 1'b0, rd_en = 1'b0, pll_lock = 1'b0;
   logic [7:0] rdata, cfg_mode, cfg_loop, cfg_dly, cfg_out, cfg_ref;
   logic [23:0] cfg_pll;
   logic pll_rst_pulse, dly_rst_pulse;

   int total = 0, bad = 0;
   bit done = 1'b0;
   logic [7:0] m_stg [8];
   logic [7:0] m_wrk [8];

   always #2 clk = ~clk;

   clksyn_regbank u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .pll_lock(pll_lock), .cfg_mode(cfg_mode),
      .cfg_pll(cfg_pll), .cfg_loop(cfg_loop), .cfg_dly(cfg_dly),
      .cfg_out(cfg_out), .cfg_ref(cfg_ref), .pll_rst_pulse(pll_rst_pulse),
      .dly_rst_pulse(dly_rst_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   function automatic bit is_shadow(int a);
      return (a >= 1 && a <= 3) || a == 5;
   endfunction

   function automatic void mdl_write(int a, logic [7:0] v);
      logic [7:0] n;
      if (a < 8) begin
         n = v;
         if (a == 1 && v[2:0] == 3'b111) n[2:0] = m_stg[1][2:0];
         if (a == 5 && v[1:0] == 2'b10)  n[1:0] = m_stg[5][1:0];
         m_stg[a] = n;
         if (!is_shadow(a)) m_wrk[a] = n;
      end else if (a == 8) begin
         if (v[3:0] == 4'hA) m_wrk[5] = m_stg[5];
         if (v[7:4] == 4'h5) for (int k = 1; k <= 3; k++) m_wrk[k] = m_stg[k];
      end
   endfunction

   function automatic logic [7:0] mdl_read(int a);
      if (a < 8)   return m_stg[a];
      if (a == 16) return 8'h17;
      if (a == 17) return 8'h01;
      if (a == 18) return {6'b0, pll_lock, 1'b0};
      return 8'h00;
   endfunction

   task automatic chk_cfg(input string tag);
      chk({tag, " mode"}, cfg_mode, m_wrk[0]);
      chk({tag, " pll"},  cfg_pll, {m_wrk[3], m_wrk[2], m_wrk[1]});
      chk({tag, " loop"}, cfg_loop, m_wrk[4]);
      chk({tag, " dly"},  cfg_dly, m_wrk[5]);
      chk({tag, " out"},  cfg_out, m_wrk[6]);
      chk({tag, " ref"},  cfg_ref, m_wrk[7]);
   endtask

   task automatic do_wr(input int a, input logic [7:0] v);
      @(negedge clk);
      addr = 5'(a); wdata = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      mdl_write(a, v);
   endtask

   task automatic do_rd(input int a, input string tag);
      @(negedge clk);
      addr = 5'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(tag, rdata, mdl_read(a));
   endtask

   initial begin
      for (int k = 0; k < 8; k++) begin
         m_stg[k] = (k == 7) ? 8'h80 : 8'h00;
         m_wrk[k] = m_stg[k];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_cfg("R1 reset");
      chk("R1 pll pulse", pll_rst_pulse, 0);
      chk("R1 dly pulse", dly_rst_pulse, 0);
      chk("R1 rdata", rdata, 0);
      for (int a = 0; a < 8; a++) do_rd(a, "R1 readback");

      // R2 R3 R8 R9: write every non-command address, then read all
      for (int a = 0; a < 32; a++) begin
         if (a == 8) continue;
         do_wr(a, 8'((a * 37 + 11) ^ 8'h04));
         chk_cfg(a < 8 ? (is_shadow(a) ? "R3 staged only" : "R2 direct") : "R9 ignored wr");
         for (int r = 0; r < 32; r++)
            do_rd(r, r < 8 ? "R2 readback" : (r >= 16 && r <= 18) ? "R8 fixed" : "R9 zero");
      end

      // R10 reserved codes, every byte value
      for (int v = 0; v < 256; v++) begin
         do_wr(1, 8'(v)); do_rd(1, "R10 idx1");
         do_wr(5, 8'(v)); do_rd(5, "R10 idx5");
      end

      // R4 R5 R6 R7: every command value with fresh staged data
      for (int v = 0; v < 256; v++) begin
         do_wr(1, 8'(v * 3 + 1));
         do_wr(2, 8'(v) ^ 8'h3C);
         do_wr(3, 8'(v + 7));
         do_wr(5, 8'(v * 5));
         chk_cfg("R3 before cmd");
         @(negedge clk);
         addr = 5'd8; wdata = 8'(v); wr_en = 1'b1;
         @(negedge clk);
         wr_en = 1'b0;
         mdl_write(8, 8'(v));
         chk(v == 8'h5A ? "R6 pll pulse" : "R5 pll pulse", pll_rst_pulse, (v[7:4] == 4'h5));
         chk(v == 8'h5A ? "R6 dly pulse" : "R4 dly pulse", dly_rst_pulse, (v[3:0] == 4'hA));
         chk_cfg((v[7:4] != 4'h5 && v[3:0] != 4'hA) ? "R7 no effect" : "R4R5 load");
         @(negedge clk);
         chk("R5 pll single", pll_rst_pulse, 0);
         chk("R4 dly single", dly_rst_pulse, 0);
      end
      do_rd(8, "R9 cmd reads zero");

      // R8 lock status both ways
      pll_lock = 1'b1; do_rd(18, "R8 lock high");
      pll_lock = 1'b0; do_rd(18, "R8 lock low");

      // R11 hold while rd_en low
      do_rd(16, "R11 load");
      @(negedge clk); addr = 5'd0;
      @(negedge clk);
      chk("R11 hold", rdata, 8'h17);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog got=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule